// File: doc/BRIEF.md
# Display Attribute Controller Port

This block is a small register bank reached through one shared byte-wide write port. Writes to that port alternate between an index byte and a data byte; an internal phase flip-flop decides which one each write is. A read strobe from a separate input-status port forces the flip-flop back to the index phase. Software uses that read to recover a known state before it starts an update.

The index byte has two jobs. Its low five bits pick one of 21 registers: sixteen colour-table entries and five control registers. Bit 5 is a live display-enable flag. While that flag is clear, the pixel output shows the border colour. While it is set, each 4-bit pixel value is masked by the plane mask and then looked up in the colour table. The lookup result appears one cycle later.

Software can read back the phase, the latched index byte and the register that the index selects.

Top module: `acp_attr_port`

## Requirements
- R1: With the phase at index (`phase_data`=0), a `port_wr` strobe latches the index byte and moves the phase to data. The next `port_wr` strobe is taken as data, and the phase returns to index on the following cycle.
- R2: A `status_rd` strobe leaves the phase at index on the next cycle. If a `port_wr` arrives in the same cycle, the write is first decoded in the current phase, and the phase still ends at index.
- R3: In an index write, bits 4:0 select the register and bit 5 is the display-enable flag. `index_rdata` returns {2'b00, enable, select}.
- R4: Indices 0x00–0x0F are colour-table entries. Each entry stores the low 6 bits of the data byte, and its bits 7:6 read back as 0.
- R5: Indices 0x10–0x14 are 8-bit control registers. Index 0x11 is the border colour (bits 5:0 are used). Index 0x12 is the plane mask (bits 3:0 are used).
- R6: Indices 0x15–0x1F select no register. A data write to such an index changes no register, and `reg_rdata` reads 0 while one is selected.
- R7: After a synchronous reset: the phase is index, the latched index byte is 0, every register is 0 and `pix_out` is 0.
- R8: With display enabled, `pix_out` equals, one cycle later, the colour-table entry at (`pix_in` AND plane mask).
- R9: With display disabled, `pix_out` equals, one cycle later, the border colour, whatever `pix_in` is.
- R10: An update that writes its index byte with bit 5 set keeps display enabled throughout, so `pix_out` never shows the border during that update.
- R11: `phase_data` reports the current phase: 0 means the next write is an index, 1 means it is data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_wr | input | 1 | Write strobe for the shared index/data port |
| port_wdata | input | 8 | Byte written to the shared port |
| status_rd | input | 1 | Read strobe of the input-status port; forces the index phase |
| phase_data | output | 1 | Current phase: 1 = next write is data |
| index_rdata | output | 8 | Latched index byte {00, enable, select} |
| reg_rdata | output | 8 | Contents of the selected register, 0 if none |
| pix_in | input | 4 | Pixel value from the video path |
| pix_out | output | 6 | Colour after lookup or border substitution |

## Verification
A behavioural model in the bench tracks the phase, the index and all 21 registers, and predicts every output on every cycle. The colour table is filled with display disabled and random pixels applied, so only the border may appear; this separates gating from lookup. Random pixels under a full mask and then a partial mask expose masking and addressing errors. Directed sequences interleave status reads with index and data writes, including a status read in the same cycle as a write, and an update made with the enable bit set; together they separate correct toggle recovery and glitch-free updates from off-by-one phase errors.

// File: rtl/attr_pkg.sv
package attr_pkg;
    localparam int unsigned IDX_W   = 5;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned PAL_N   = 16;
    localparam int unsigned CTRL_N  = 5;
    localparam int unsigned COLOR_W = 6;
    localparam int unsigned PIX_W   = 4;
    localparam int unsigned REG_N   = PAL_N + CTRL_N;
    localparam int unsigned EN_BIT  = 5;

    localparam logic [IDX_W-1:0] BORDER_SEL = IDX_W'(5'h11);
    localparam logic [IDX_W-1:0] MASK_SEL   = IDX_W'(5'h12);

    typedef enum logic {
        PH_INDEX = 1'b0,
        PH_DATA  = 1'b1
    } phase_e;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] sel;
    } index_t;

    typedef struct packed {
        logic              valid;
        logic [IDX_W-1:0]  sel;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic logic sel_mapped(input logic [IDX_W-1:0] s);
        return 32'(s) < REG_N;
    endfunction

    function automatic logic sel_palette(input logic [IDX_W-1:0] s);
        return 32'(s) < PAL_N;
    endfunction
endpackage

// File: rtl/acp_toggle.sv
module acp_toggle
    import attr_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          port_wr,
    input  logic [DW-1:0] port_wdata,
    input  logic          status_rd,
    output phase_e        phase,
    output index_t        idx,
    output wr_req_t       req
);
    phase_e phase_q;
    index_t idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_INDEX;
            idx_q   <= '0;
        end else begin
            if (port_wr && phase_q == PH_INDEX) begin
                idx_q.sel <= port_wdata[IW-1:0];
                idx_q.en  <= port_wdata[EN_BIT];
            end
            if (status_rd) begin
                phase_q <= PH_INDEX;
            end else if (port_wr) begin
                phase_q <= (phase_q == PH_INDEX) ? PH_DATA : PH_INDEX;
            end
        end
    end

    always_comb begin
        req.valid = port_wr && (phase_q == PH_DATA) && sel_mapped(idx_q.sel);
        req.sel   = idx_q.sel;
        req.data  = port_wdata;
    end

    assign phase = phase_q;
    assign idx   = idx_q;

    p_status_forces_index_r2: assert property (@(posedge clk) disable iff (rst)
        status_rd |=> (phase == PH_INDEX));
    p_data_returns_index_r1: assert property (@(posedge clk) disable iff (rst)
        (port_wr && phase == PH_DATA) |=> (phase == PH_INDEX));
    p_index_goes_data_r1: assert property (@(posedge clk) disable iff (rst)
        (port_wr && phase == PH_INDEX && !status_rd) |=> (phase == PH_DATA));
    p_index_held_in_data_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DATA) |=> $stable(idx));
endmodule

// File: rtl/acp_regbank.sv
module acp_regbank
    import attr_pkg::*;
#(
    parameter int unsigned NREG = REG_N,
    parameter int unsigned NPAL = PAL_N,
    parameter int unsigned DW   = DATA_W,
    parameter int unsigned CW   = COLOR_W,
    parameter int unsigned PW   = PIX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  wr_req_t       req,
    input  index_t        idx,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] pal [NPAL],
    output logic [CW-1:0] border,
    output logic [PW-1:0] plane_mask
);
    localparam logic [DW-1:0] PAL_KEEP = DW'((1 << CW) - 1);

    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [DW-1:0] KEEP = (g < NPAL) ? PAL_KEEP : '1;
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (req.valid && 32'(req.sel) == g) begin
                regs[g] <= req.data & KEEP;
            end
        end
    end

    for (genvar p = 0; p < NPAL; p++) begin : g_pal
        assign pal[p] = regs[p][CW-1:0];
    end

    assign border     = regs[BORDER_SEL][CW-1:0];
    assign plane_mask = regs[MASK_SEL][PW-1:0];

    always_comb begin
        rd_data = '0;
        if (sel_mapped(idx.sel)) begin
            rd_data = regs[idx.sel];
        end
    end

    p_palette_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
        sel_palette(idx.sel) |-> (rd_data[DW-1:CW] == '0));
endmodule

// File: rtl/acp_pixel.sv
module acp_pixel
    import attr_pkg::*;
#(
    parameter int unsigned NPAL = PAL_N,
    parameter int unsigned CW   = COLOR_W,
    parameter int unsigned PW   = PIX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          disp_en,
    input  logic [PW-1:0] pix_in,
    input  logic [PW-1:0] plane_mask,
    input  logic [CW-1:0] pal [NPAL],
    input  logic [CW-1:0] border,
    output logic [CW-1:0] pix_out
);
    logic [PW-1:0] lookup_sel;
    logic [CW-1:0] colour;

    assign lookup_sel = pix_in & plane_mask;
    assign colour     = disp_en ? pal[lookup_sel] : border;

    always_ff @(posedge clk) begin
        if (rst) pix_out <= '0;
        else     pix_out <= colour;
    end

    p_blank_shows_border_r9: assert property (@(posedge clk) disable iff (rst)
        !disp_en |=> (pix_out == $past(border)));
endmodule

// File: rtl/acp_attr_port.sv
module acp_attr_port
    import attr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                port_wr,
    input  logic [DATA_W-1:0]   port_wdata,
    input  logic                status_rd,
    output logic                phase_data,
    output logic [DATA_W-1:0]   index_rdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [PIX_W-1:0]    pix_in,
    output logic [COLOR_W-1:0]  pix_out
);
    phase_e            phase;
    index_t            idx;
    wr_req_t           req;
    logic [COLOR_W-1:0] pal [PAL_N];
    logic [COLOR_W-1:0] border;
    logic [PIX_W-1:0]   plane_mask;

    acp_toggle u_toggle (
        .clk       (clk),
        .rst       (rst),
        .port_wr   (port_wr),
        .port_wdata(port_wdata),
        .status_rd (status_rd),
        .phase     (phase),
        .idx       (idx),
        .req       (req)
    );

    acp_regbank u_bank (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .idx       (idx),
        .rd_data   (reg_rdata),
        .pal       (pal),
        .border    (border),
        .plane_mask(plane_mask)
    );

    acp_pixel u_pixel (
        .clk       (clk),
        .rst       (rst),
        .disp_en   (idx.en),
        .pix_in    (pix_in),
        .plane_mask(plane_mask),
        .pal       (pal),
        .border    (border),
        .pix_out   (pix_out)
    );

    assign phase_data  = (phase == PH_DATA);
    assign index_rdata = DATA_W'({idx.en, idx.sel});

    p_enable_index_keeps_display_r10: assert property (@(posedge clk) disable iff (rst)
        (!phase_data && port_wr && port_wdata[EN_BIT]) |=> idx.en);
    p_unmapped_write_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (phase_data && port_wr && !sel_mapped(idx.sel)) |=>
            ($stable(border) && $stable(plane_mask)));
endmodule

// File: tb/acp_attr_port_tb_top.sv
module acp_attr_port_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       port_wr = 1'b0;
    logic [7:0] port_wdata = '0;
    logic       status_rd = 1'b0;
    logic       phase_data;
    logic [7:0] index_rdata;
    logic [7:0] reg_rdata;
    logic [3:0] pix_in = '0;
    logic [5:0] pix_out;

    int checks = 0;
    int fails  = 0;
    bit armed  = 0;
    bit done   = 0;
    bit watch  = 0;
    int border_seen = 0;
    int cyc = 0;

    // behavioural reference state
    int m_ph, m_idx, m_en, m_pix;
    int m_regs [32];

    always #4 clk = ~clk;

    acp_attr_port dut_i (
        .clk(clk), .rst(rst), .port_wr(port_wr), .port_wdata(port_wdata),
        .status_rd(status_rd), .phase_data(phase_data), .index_rdata(index_rdata),
        .reg_rdata(reg_rdata), .pix_in(pix_in), .pix_out(pix_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_ph = 0; m_idx = 0; m_en = 0; m_pix = 0;
            foreach (m_regs[i]) m_regs[i] = 0;
        end else begin
            int msk;
            msk = m_regs[18] & 15;
            m_pix = m_en ? (m_regs[int'(pix_in) & msk] & 63) : (m_regs[17] & 63);
            if (port_wr) begin
                if (m_ph == 0) begin
                    m_idx = int'(port_wdata) & 31;
                    m_en  = (int'(port_wdata) >> 5) & 1;
                    m_ph  = 1;
                end else begin
                    if (m_idx < 21)
                        m_regs[m_idx] = (m_idx < 16) ? (int'(port_wdata) & 63) : int'(port_wdata);
                    m_ph = 0;
                end
            end
            if (status_rd) m_ph = 0;
        end
    end

    always @(negedge clk) begin
        if (armed && !rst) begin
            chk("R1 R2 R11 phase", int'(phase_data), m_ph);
            chk("R3 index readback", int'(index_rdata), (m_en << 5) | m_idx);
            chk(m_idx < 16 ? "R4 reg readback" : (m_idx < 21 ? "R5 reg readback" : "R6 reg readback"),
                int'(reg_rdata), m_idx < 21 ? m_regs[m_idx] : 0);
            chk(m_en ? "R8 pixel lookup" : "R9 border", int'(pix_out), m_pix);
            if (watch && int'(pix_out) == (m_regs[17] & 63)) border_seen++;
        end
        pix_in <= 4'($urandom);
    end

    task automatic wr(input logic [7:0] b);
        @(negedge clk);
        port_wr = 1'b1; port_wdata = b;
        @(negedge clk);
        port_wr = 1'b0;
    endtask

    task automatic stat_rd();
        @(negedge clk);
        status_rd = 1'b1;
        @(negedge clk);
        status_rd = 1'b0;
    endtask

    always @(posedge clk) begin
        if (!done && cyc > 20000) begin
            fails++;
            $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R7: reset state
        chk("R7 phase", int'(phase_data), 0);
        chk("R7 index", int'(index_rdata), 0);
        chk("R7 reg", int'(reg_rdata), 0);
        chk("R7 pix", int'(pix_out), 0);
        armed = 1;

        // R4: fill colour table, display disabled (R9 exercised meanwhile)
        for (int i = 0; i < 16; i++) begin
            wr(8'(i)); wr(8'(i * 3 + 1) | 8'hC0);
        end
        wr(8'h11); wr(8'hEA);      // R5 border = 0x2A
        wr(8'h12); wr(8'h0F);      // R5 plane mask
        wr(8'h13); wr(8'h5A);
        wr(8'h17); wr(8'h55);      // R6 unmapped write
        repeat (3) @(negedge clk);
        wr(8'h11); stat_rd();      // R2 recovery, next write is index
        wr(8'h12); wr(8'h0F);
        // R8: display on, random pixels
        wr(8'h20);
        stat_rd();
        repeat (40) @(negedge clk);
        // R10: update with enable bit held
        watch = 1;
        wr(8'h25); wr(8'h15);
        wr(8'h2C); wr(8'h0B);
        repeat (4) @(negedge clk);
        watch = 0;
        chk("R10 border never shown", border_seen, 0);
        // R8 with partial mask
        wr(8'h32); wr(8'h05);
        repeat (30) @(negedge clk);
        // R2: status read coincident with index write
        @(negedge clk);
        port_wr = 1'b1; port_wdata = 8'h03; status_rd = 1'b1;
        @(negedge clk);
        port_wr = 1'b0; status_rd = 1'b0;
        // status read coincident with data write
        wr(8'h24);
        @(negedge clk);
        port_wr = 1'b1; port_wdata = 8'h3E; status_rd = 1'b1;
        @(negedge clk);
        port_wr = 1'b0; status_rd = 1'b0;
        wr(8'h1F); wr(8'hFF);      // R6 top unmapped index
        wr(8'h04); wr(8'h21);      // display off again (R9)
        repeat (20) @(negedge clk);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule